// File: doc/BRIEF.md
# Bit-Serial Check-Byte Engine for 64-Bit Device Identities

This block keeps an 8-bit running remainder over a device identity that arrives one bit at a time. Each cycle in which the bit-valid strobe is high, the incoming bit joins the remainder. The data bits enter least significant bit first: the 8-bit family code goes in first, then the 48-bit serial number. When those 56 bits have gone in, the remainder equals the check byte to transmit, or to compare against a received one.

The same engine also checks a complete 64-bit identity. If the 8 check-byte bits are shifted in after the 56 data bits, the remainder returns to all zeros and the zero-residue flag goes high. A synchronous clear starts a new computation. The block does not parse bus waveforms, frame bytes, or store the identity.

Top module: `crc8s_serial`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted bit, the remainder reads 8'h00 and the zero-residue flag reads 1.
- R2: A cycle with the clear input high leaves the remainder at 8'h00 after the next rising clock edge.
- R3: When clear and bit-valid are both high in the same cycle, clear wins: the remainder becomes 8'h00, whatever the data bit is.
- R4: In a cycle with bit-valid low and clear low, the remainder keeps its value, whatever the data bit is.
- R5: On an accepted bit, the new remainder is the old one shifted right by one place. If the data bit XOR old bit 0 is 1, that value is then XORed with 8'h8C (the reflected form of x^8+x^5+x^4+1). From a zero remainder, a 1 gives 8'h8C and a 0 gives 8'h00.
- R6: From a cleared state, shifting in family code 8'h02 and serial number 48'h000001B81C (56 bits, each byte LSB first, family code first) leaves the remainder at 8'hA2.
- R7: Shifting in the 8 check-byte bits, LSB first, after their 56 data bits leaves the remainder at 8'h00.
- R8: The zero-residue flag is 1 exactly when the remainder is 8'h00, in the same cycle, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous clear of the remainder; has priority over bit_vld |
| bit_vld | input | 1 | Accepts bit_in on this rising edge |
| bit_in | input | 1 | Serial data bit |
| crc | output | 8 | Current remainder |
| residue_zero | output | 1 | High when the remainder is zero |

## Verification
A single 1 shifted into a zero remainder separates a correct feedback constant and tap direction from a wrong one. A known identity with a fixed check byte catches errors in bit order, byte order and initial value. Several generated identities, each followed by its own computed check byte, confirm that the remainder returns to zero across many feedback patterns. Idle cycles driven with the data bit toggling show that an unaccepted bit leaves the remainder unchanged. A clear issued together with a valid 1 bit confirms that clear has priority.

// File: rtl/crc8s_pkg.sv
package crc8s_pkg;
  localparam int unsigned CRC_W = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/crc8s_rst_sync.sv
module crc8s_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/crc8s_step.sv
module crc8s_step
  import crc8s_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = POLY_REFL
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic fb;
  logic [W-1:0] shifted;

  always_comb begin
    fb      = din ^ cur[0];
    shifted = {1'b0, cur[W-1:1]};
    nxt     = fb ? (shifted ^ POLY) : shifted;
  end
endmodule

// File: rtl/crc8s_state.sv
module crc8s_state
  import crc8s_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = POLY_REFL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  input  logic [W-1:0] step_val,
  output logic [W-1:0] rem_q
);
  logic [W-1:0] rem_d;

  always_comb begin
    rem_d = rem_q;
    if (clr)     rem_d = '0;
    else if (en) rem_d = step_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rem_q == '0)); // R2
  AST_CLR_OVER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && en && din) |=> (rem_q == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(rem_q)); // R4
  AST_ONE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en && din && rem_q == '0) |=> (rem_q == POLY)); // R5
  AST_ZERO_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en && !din && rem_q == '0) |=> (rem_q == '0)); // R5
endmodule

// File: rtl/crc8s_serial.sv
module crc8s_serial
  import crc8s_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = POLY_REFL,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bit_vld,
  input  logic         bit_in,
  output logic [W-1:0] crc,
  output logic         residue_zero
);
  logic         rst_n_int;
  logic [W-1:0] rem_q;
  logic [W-1:0] step_val;

  crc8s_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  crc8s_step #(.W(W), .POLY(POLY)) i_step (
    .cur (rem_q),
    .din (bit_in),
    .nxt (step_val)
  );

  crc8s_state #(.W(W), .POLY(POLY)) i_state (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (clr),
    .en       (bit_vld),
    .din      (bit_in),
    .step_val (step_val),
    .rem_q    (rem_q)
  );

  assign crc          = rem_q;
  assign residue_zero = ~|rem_q;

  AST_FLAG_FALLS_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!clr && bit_vld && bit_in && rem_q == '0) |=> !residue_zero); // R8
endmodule

// File: tb/test_crc8s_serial.sv
module test_crc8s_serial;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] crc;
  logic       residue_zero;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [7:0] exp_crc;
    string      tag;
  } item_t;
  item_t sb_q[$];
  logic [7:0] model = 8'h00;

  always #2.5 clk = ~clk;

  crc8s_serial i_crc8s_serial (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld),
    .bit_in(bit_in), .crc(crc), .residue_zero(residue_zero)
  );

  function automatic logic [7:0] ref_step(logic [7:0] c, logic b);
    logic [7:0] r;
    r = c >> 1;
    if (b ^ c[0]) r = r ^ 8'h8C;
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic c, logic v, logic b, string tag);
    @(negedge clk);
    clr = c; bit_vld = v; bit_in = b;
    if (c) model = 8'h00;
    else if (v) model = ref_step(model, b);
    sb_q.push_back('{model, tag});
  endtask

  task automatic shift_byte(logic [7:0] d, string tag);
    for (int i = 0; i < 8; i++) drive(1'b0, 1'b1, d[i], tag);
  endtask

  // Monitor: compares one expected item per clock, after the edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check({it.tag, " crc"}, crc, it.exp_crc);
        check({"R8 flag (", it.tag, ")"}, {7'd0, residue_zero},
              {7'd0, (it.exp_crc == 8'h00)});
      end
    end
  end

  initial begin
    #(5 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] ident [7];
    logic [7:0] chk;
    #7;
    check("R1 in reset", crc, 8'h00);
    check("R1 flag in reset", {7'd0, residue_zero}, 8'd1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after release", crc, 8'h00);
    check("R1 flag after release", {7'd0, residue_zero}, 8'd1);

    drive(1'b0, 1'b1, 1'b1, "R5 one from zero");
    drive(1'b0, 1'b0, 1'b1, "R4 idle bit1");
    drive(1'b0, 1'b0, 1'b0, "R4 idle bit0");
    drive(1'b0, 1'b1, 1'b0, "R5 zero into 8C");
    drive(1'b1, 1'b0, 1'b0, "R2 clear");
    drive(1'b0, 1'b1, 1'b1, "R5 one again");
    drive(1'b1, 1'b1, 1'b1, "R3 clear over valid");

    // Known identity: family 02, serial 000001B81C, check byte A2
    ident = '{8'h02, 8'h1C, 8'hB8, 8'h01, 8'h00, 8'h00, 8'h00};
    foreach (ident[k]) shift_byte(ident[k], "R6 data");
    drive(1'b0, 1'b0, 1'b0, "R6 idle");
    repeat (3) @(posedge clk);
    check("R6 known check byte", model, 8'hA2);
    shift_byte(8'hA2, "R7 check byte");
    drive(1'b0, 1'b0, 1'b1, "R7 residue");

    for (int n = 0; n < 6; n++) begin
      drive(1'b1, 1'b0, 1'b0, "R2 clear before id");
      foreach (ident[k]) ident[k] = 8'($urandom);
      ident[0] = 8'(n * 37 + 1);
      foreach (ident[k]) shift_byte(ident[k], "R5 data");
      chk = model;
      shift_byte(chk, "R7 generated id");
      drive(1'b0, 1'b0, 1'b0, "R7 zero residue");
      repeat (3) @(posedge clk);
      check("R7 residue back to zero", model, 8'h00);
    end

    repeat (4) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule